// File: doc/BRIEF.md
# Sequential Ones' Complement Multiply/Divide Unit

This block is an iterative arithmetic engine for 36-bit ones' complement words, where bit 35 is the sign and bits 34:0 are the magnitude. It works on two word registers: the accumulator (AC) and the in-out register (IO). A start strobe presents the current AC and IO contents, an operand word and an operation select. The unit converts every word to sign and magnitude, iterates under an internal step counter, and then writes new AC and IO words back with an overflow indication and a single-cycle done pulse.

Multiply forms the 70-bit product of the AC and the operand, split across AC (high half) and IO (low half). It is a shift-and-add engine: the multiplier is the AC magnitude, and a step whose multiplier bit is 1 costs one extra cycle for the add. Divide treats AC and IO as a double-length dividend and the operand as the divisor. It leaves the quotient in IO and the remainder in AC, using 35 restoring steps. If the quotient cannot fit, the divide is abandoned at once with overflow raised and both registers returned untouched.

Start is plain control with one back-pressure rule. A start is taken only in a cycle where `busy` is low. A start raised while `busy` is high is dropped and has no effect, so the driver must hold or repeat it. The cycle in which `done` is high already has `busy` low, so a new operation may start in that cycle.

Top module: `seq_muldiv`

## Requirements
- R1: With `op_div`=0 (multiply), let s = ac_in[35] XOR opnd_in[35] and P = |AC| * |operand| (70 bits). After the operation, ac_out = {s, P[69:35]} and io_out = {s, P[34:0]}, with each 35-bit magnitude field bit-inverted when s=1.
- R2: With `op_div`=1 (divide), the dividend magnitude is {|AC|, |IO|}, where each register is converted by its own sign. The quotient Q and remainder Rm are computed against the divisor magnitude |operand|. io_out = {sq, Q} with sq = ac_in[35] XOR opnd_in[35]. ac_out = {ac_in[35], Rm}. A magnitude field is inverted when its sign bit is 1.
- R3: A divide with |AC| >= |operand| (this includes a zero divisor) sets `ovf`. It returns ac_out = ac_in and io_out = io_in as presented at start, and raises `done` 1 cycle after the start edge.
- R4: `ovf` is updated only when `done` is raised. It is 0 after every multiply and every divide that fits, and it holds its value until the next `done`.
- R5: A word whose magnitude bits are all 1 (negative zero) counts as magnitude 0. Its sign bit still enters the result signs.
- R6: `done` rises 36 + N cycles after the start edge for a multiply, where N is the number of 1 bits in |AC|. It rises 36 cycles after the start edge for a divide that does not overflow.
- R7: `done` is a one-cycle pulse. `busy` is high from the cycle after an accepted start until `done` rises, and `done` is never high while `busy` is high.
- R8: A start while `busy` is high is ignored: the running operation's result and timing are unchanged.
- R9: After reset, `busy`, `done` and `ovf` are 0 and ac_out and io_out are all zero.
- R10: ac_out and io_out change only in the cycle in which `done` is high, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Starts an operation when `busy` is low |
| op_div | input | 1 | 0 = multiply, 1 = divide; sampled with start |
| ac_in | input | 36 | Current AC word, sampled with start |
| io_in | input | 36 | Current IO word, sampled with start |
| opnd_in | input | 36 | Multiplicand or divisor word, sampled with start |
| ac_out | output | 36 | New AC word: high product or remainder |
| io_out | output | 36 | New IO word: low product or quotient |
| ovf | output | 1 | Divide overflow, valid from `done` |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in progress; start is refused |

## Verification
Two events can fall in the same cycle: the completion of one operation, and the start of the next. The bench provokes this by raising the following start in exactly the cycle in which it sees `done`. It judges the case by the follow-on operation's latency and result, both computed from the requirements. It also injects a stray start with different inputs in the middle of a running operation, and checks that the running operation's result and cycle count match the values expected without the stray start.

// File: rtl/md_pkg.sv
package md_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_DIV  = 2'd2,
    ST_FIN  = 2'd3
  } md_state_t;

  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } md_op_t;

  localparam int MD_WORD_W = 36;
endpackage

// File: rtl/md_mag_conv.sv
module md_mag_conv #(
  parameter int WORD_W = 36,
  localparam int MAG_W = WORD_W - 1
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [MAG_W-1:0]  mag_o
);
  // Negative words hold the inverted magnitude; all-ones magnitude maps to 0.
  always_comb begin
    mag_o = word_i[WORD_W-1] ? ~word_i[MAG_W-1:0] : word_i[MAG_W-1:0];
  end
endmodule

// File: rtl/md_sign_apply.sv
module md_sign_apply #(
  parameter int WORD_W = 36,
  localparam int MAG_W = WORD_W - 1
) (
  input  logic              sign_i,
  input  logic [MAG_W-1:0]  mag_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    word_o = {sign_i, sign_i ? ~mag_i : mag_i};
  end
endmodule

// File: rtl/md_div_step.sv
module md_div_step #(
  parameter int MAG_W = 35
) (
  input  logic [MAG_W-1:0] rem_i,
  input  logic [MAG_W-1:0] quo_i,
  input  logic [MAG_W-1:0] dvs_i,
  output logic [MAG_W-1:0] rem_o,
  output logic [MAG_W-1:0] quo_o
);
  logic [MAG_W:0] shifted;
  logic [MAG_W:0] diff;
  logic           fits;

  // One restoring step: bring down the next dividend bit, then try to subtract.
  always_comb begin
    shifted = {rem_i, quo_i[MAG_W-1]};
    diff    = shifted - {1'b0, dvs_i};
    fits    = (shifted >= {1'b0, dvs_i});
    rem_o   = fits ? diff[MAG_W-1:0] : shifted[MAG_W-1:0];
    quo_o   = {quo_i[MAG_W-2:0], fits};
  end
endmodule

// File: rtl/seq_muldiv.sv
module seq_muldiv
  import md_pkg::*;
#(
  parameter int WORD_W = MD_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_div,
  input  logic [WORD_W-1:0] ac_in,
  input  logic [WORD_W-1:0] io_in,
  input  logic [WORD_W-1:0] opnd_in,
  output logic [WORD_W-1:0] ac_out,
  output logic [WORD_W-1:0] io_out,
  output logic              ovf,
  output logic              done,
  output logic              busy
);
  localparam int MAG_W = WORD_W - 1;
  localparam int CNT_W = $clog2(MAG_W + 1);
  localparam int NUM_IN = 3;
  localparam logic [CNT_W-1:0] STEPS = CNT_W'(MAG_W);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // Input words: 0 = AC, 1 = IO, 2 = operand
  logic [NUM_IN-1:0][WORD_W-1:0] words_in;
  logic [NUM_IN-1:0][MAG_W-1:0]  mags_in;
  assign words_in = {opnd_in, io_in, ac_in};

  for (genvar g = 0; g < NUM_IN; g++) begin : g_conv
    md_mag_conv #(.WORD_W(WORD_W)) u_conv (
      .word_i(words_in[g]),
      .mag_o (mags_in[g])
    );
  end

  md_state_t         state_q;
  md_op_t            op_q;
  logic [WORD_W-1:0] ac_sv, io_sv;
  logic              sa_q, sb_q;
  logic [MAG_W-1:0]  mcand_q;
  logic [MAG_W-1:0]  hi_q, lo_q;
  logic              carry_q, added_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ovf_pend, ovf_q, done_q;
  logic [WORD_W-1:0] ac_out_q, io_out_q;

  logic              accept, ovf_det;
  logic [MAG_W-1:0]  rem_nx, quo_nx;
  logic              hi_sign;
  logic [WORD_W-1:0] hi_word, lo_word;

  assign accept  = start && (state_q == ST_IDLE);
  assign ovf_det = (mags_in[0] >= mags_in[2]);

  md_div_step #(.MAG_W(MAG_W)) u_step (
    .rem_i(hi_q),
    .quo_i(lo_q),
    .dvs_i(mcand_q),
    .rem_o(rem_nx),
    .quo_o(quo_nx)
  );

  assign hi_sign = (op_q == OP_DIV) ? sa_q : (sa_q ^ sb_q);

  md_sign_apply #(.WORD_W(WORD_W)) u_hi_sign (
    .sign_i(hi_sign), .mag_i(hi_q), .word_o(hi_word)
  );
  md_sign_apply #(.WORD_W(WORD_W)) u_lo_sign (
    .sign_i(sa_q ^ sb_q), .mag_i(lo_q), .word_o(lo_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_MUL;
      ac_sv    <= '0;
      io_sv    <= '0;
      sa_q     <= 1'b0;
      sb_q     <= 1'b0;
      mcand_q  <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
      carry_q  <= 1'b0;
      added_q  <= 1'b0;
      cnt_q    <= '0;
      ovf_pend <= 1'b0;
      ovf_q    <= 1'b0;
      done_q   <= 1'b0;
      ac_out_q <= '0;
      io_out_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            op_q    <= op_div ? OP_DIV : OP_MUL;
            ac_sv   <= ac_in;
            io_sv   <= io_in;
            sa_q    <= ac_in[WORD_W-1];
            sb_q    <= opnd_in[WORD_W-1];
            mcand_q <= mags_in[2];
            cnt_q   <= STEPS;
            carry_q <= 1'b0;
            added_q <= 1'b0;
            if (op_div) begin
              hi_q     <= mags_in[0];
              lo_q     <= mags_in[1];
              ovf_pend <= ovf_det;
              state_q  <= ovf_det ? ST_FIN : ST_DIV;
            end else begin
              hi_q     <= '0;
              lo_q     <= mags_in[0];
              ovf_pend <= 1'b0;
              state_q  <= ST_MUL;
            end
          end
        end
        ST_MUL: begin
          if (lo_q[0] && !added_q) begin
            {carry_q, hi_q} <= {1'b0, hi_q} + {1'b0, mcand_q};
            added_q         <= 1'b1;
          end else begin
            hi_q    <= {carry_q, hi_q[MAG_W-1:1]};
            lo_q    <= {hi_q[0], lo_q[MAG_W-1:1]};
            carry_q <= 1'b0;
            added_q <= 1'b0;
            cnt_q   <= cnt_q - ONE;
            if (cnt_q == ONE) state_q <= ST_FIN;
          end
        end
        ST_DIV: begin
          hi_q  <= rem_nx;
          lo_q  <= quo_nx;
          cnt_q <= cnt_q - ONE;
          if (cnt_q == ONE) state_q <= ST_FIN;
        end
        ST_FIN: begin
          ovf_q  <= ovf_pend;
          done_q <= 1'b1;
          if (ovf_pend) begin
            ac_out_q <= ac_sv;
            io_out_q <= io_sv;
          end else begin
            ac_out_q <= hi_word;
            io_out_q <= lo_word;
          end
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ac_out = ac_out_q;
  assign io_out = io_out_q;
  assign ovf    = ovf_q;
  assign done   = done_q;
  assign busy   = (state_q != ST_IDLE);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R3
  ovf_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ovf) |-> (ac_out == ac_sv && io_out == io_sv));

  // R4
  ovf_div_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ovf) |-> (op_q == OP_DIV));

  // R2
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DIV) |-> (hi_q < mcand_q));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(ac_sv) && $stable(io_sv) && $stable(mcand_q)));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(ac_out) && $stable(io_out)));
endmodule

// File: tb/seq_muldiv_test.sv
`timescale 1ns/100ps
module seq_muldiv_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op_div = 1'b0;
  logic [35:0] ac_in = '0, io_in = '0, opnd_in = '0;
  logic [35:0] ac_out, io_out;
  logic        ovf, done, busy;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  seq_muldiv uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
    .ac_in(ac_in), .io_in(io_in), .opnd_in(opnd_in),
    .ac_out(ac_out), .io_out(io_out), .ovf(ovf), .done(done), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [34:0] mag(input logic [35:0] w);
    return w[35] ? ~w[34:0] : w[34:0];
  endfunction

  function automatic logic [35:0] signed_word(input logic s, input logic [34:0] m);
    return {s, s ? ~m : m};
  endfunction

  function automatic logic [35:0] r36();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[35:0];
  endfunction

  task automatic model(input logic div, input logic [35:0] a, input logic [35:0] io,
                       input logic [35:0] b, output logic [35:0] e_ac,
                       output logic [35:0] e_io, output logic e_ovf, output int e_lat);
    logic [69:0] p, d, q, r;
    logic        s;
    s = a[35] ^ b[35];
    if (!div) begin
      p     = {35'd0, mag(a)} * {35'd0, mag(b)};
      e_ac  = signed_word(s, p[69:35]);
      e_io  = signed_word(s, p[34:0]);
      e_ovf = 1'b0;
      e_lat = 36 + $countones(mag(a));
    end else if (mag(a) >= mag(b)) begin
      e_ac  = a;
      e_io  = io;
      e_ovf = 1'b1;
      e_lat = 1;
    end else begin
      d     = {mag(a), mag(io)};
      q     = d / {35'd0, mag(b)};
      r     = d % {35'd0, mag(b)};
      e_io  = signed_word(s, q[34:0]);
      e_ac  = signed_word(a[35], r[34:0]);
      e_ovf = 1'b0;
      e_lat = 36;
    end
  endtask

  // Drive one operation at the current negedge; poke_at > 0 injects a stray start.
  task automatic run_op(input logic div, input logic [35:0] a, input logic [35:0] io,
                        input logic [35:0] b, input int poke_at, input string req);
    logic [35:0] e_ac, e_io;
    logic        e_ovf;
    int          e_lat, cyc;
    model(div, a, io, b, e_ac, e_io, e_ovf, e_lat);
    start = 1'b1; op_div = div; ac_in = a; io_in = io; opnd_in = b;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; ac_in = r36(); io_in = r36(); opnd_in = r36();
    // R7: busy after accept, no done yet
    check(busy === 1'b1 && done === 1'b0, "R7", "busy/done after start",
          {62'd0, busy, done}, 64'd2);
    cyc = 0;
    while (done !== 1'b1 && cyc < 200) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
      if (cyc == poke_at && done !== 1'b1) begin
        start = 1'b1; op_div = ~div; ac_in = r36(); opnd_in = r36();
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    check(cyc == e_lat, req, "latency", 64'(cyc), 64'(e_lat));
    check(ac_out === e_ac, req, "ac_out", {28'd0, ac_out}, {28'd0, e_ac});
    check(io_out === e_io, req, "io_out", {28'd0, io_out}, {28'd0, e_io});
    check(ovf === e_ovf, req, "ovf", {63'd0, ovf}, {63'd0, e_ovf});
  endtask

  initial begin
    #500000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [35:0] a, b, io, hold_ac, hold_io;
    logic [34:0] bm;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    // R9: reset state
    check(busy === 1'b0 && done === 1'b0 && ovf === 1'b0, "R9", "flags in reset",
          {61'd0, busy, done, ovf}, 64'd0);
    check(ac_out === '0 && io_out === '0, "R9", "outputs in reset",
          {28'd0, ac_out}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 directed: small positive and mixed signs
    run_op(1'b0, 36'd7, 36'd0, 36'd9, 0, "R1");
    run_op(1'b0, signed_word(1'b1, 35'd12345), 36'd0, 36'd678, 0, "R1");
    // R6: all-ones multiplier, the longest multiply
    run_op(1'b0, {1'b0, {35{1'b1}}}, 36'd0, {1'b0, {35{1'b1}}}, 0, "R6");
    // R5: negative zero multiplier gives a zero magnitude, negative sign
    run_op(1'b0, {36{1'b1}}, 36'd0, 36'd55, 0, "R5");
    // R5: negative zero dividend high part with negative zero low part
    run_op(1'b1, {36{1'b1}}, {36{1'b1}}, 36'd3, 0, "R5");
    // R3: divisor -0 is zero magnitude, so overflow
    run_op(1'b1, 36'd0, 36'd99, {36{1'b1}}, 0, "R3");
    // R3: equal magnitudes overflow
    run_op(1'b1, signed_word(1'b1, 35'd40), 36'd17, 36'd40, 0, "R3");
    // R4: ovf clears on a following good divide (issued in the done cycle)
    run_op(1'b1, 36'd5, 36'd1000, 36'd9, 0, "R4");
    // R2 directed: negative dividend, positive divisor
    run_op(1'b1, signed_word(1'b1, 35'd2), signed_word(1'b1, 35'd777), 36'd11, 0, "R2");
    // R8: stray start mid multiply and mid divide
    run_op(1'b0, 36'h0_1234_5678, 36'd0, 36'h0_0ABC_DEF1, 10, "R8");
    run_op(1'b1, 36'd3, 36'h1_0000_0001, 36'd1000, 20, "R8");

    // R10: outputs hold while idle with changing inputs
    hold_ac = ac_out; hold_io = io_out;
    repeat (5) begin
      ac_in = r36(); io_in = r36(); opnd_in = r36();
      @(negedge clk);
    end
    check(ac_out === hold_ac && io_out === hold_io, "R10", "hold while idle",
          {28'd0, ac_out}, {28'd0, hold_ac});
    // R4: ovf holds while idle after an overflow
    run_op(1'b1, 36'd50, 36'd1, 36'd20, 0, "R3");
    repeat (4) @(negedge clk);
    check(ovf === 1'b1, "R4", "ovf held", {63'd0, ovf}, 64'd1);

    // Random mix, back-to-back
    for (int i = 0; i < 60; i++) begin
      a  = r36();
      b  = r36();
      io = r36();
      if ($urandom_range(0, 9) == 0) a = {a[35], a[35] ? {35{1'b1}} : 35'd0};
      if (i % 2 == 0) begin
        run_op(1'b0, a, io, b, (i % 7 == 0) ? 5 : 0, "R1");
      end else begin
        bm = mag(b);
        if (bm == '0) bm = 35'd1;
        if ($urandom_range(0, 5) != 0) a = signed_word(a[35], mag(a) % bm);
        run_op(1'b1, a, io, signed_word(b[35], bm), (i % 5 == 1) ? 7 : 0, "R2");
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule